// File: doc/BRIEF.md
# Ping-Pong Frame Buffer for a Block Transform

This block sits between a free-running sample converter and a block transform engine that wants whole frames. Samples arrive on one clock with a valid strobe and are never paused. The block gathers them into frames of a fixed, parameterised length and keeps two frame memories. One memory fills while the other is streamed out. Each streamed frame is a packet with valid, start-of-packet and end-of-packet markers, and the packet obeys a ready signal from the transform side.

Before a sample is stored it is conditioned. In offset-binary mode the top bit is flipped to give two's complement, and the result is sign-extended to the sink width. In unsigned mode the code is zero-extended, so it stays non-negative and carries a positive DC level. The imaginary output is always zero.

The two memories swap roles when a frame has been fully captured and the previous frame has been fully issued. A frame can complete while the other memory is still draining. In that case a sticky overflow flag is raised, and new samples are discarded until the swap, so no frame already in flight is disturbed.

Top module: `pp_frame_buffer`

## Requirements
- R1: After a synchronous active-low reset, outValid, outSop, outEop and overflow are all 0, and capture restarts at the first sample of a new frame.
- R2: No output word appears until FRAME_LEN samples have been captured. When outReady is high and the read side is idle, outValid rises with outSop in the second cycle after the clock edge that captures the last sample.
- R3: Every captured sample is output exactly once, in arrival order, with frames in capture order and no extra or repeated words.
- R4: outSop is 1 exactly on word 0 of a frame and outEop is 1 exactly on word FRAME_LEN-1. Both are 0 on every other word.
- R5: With cfgOffsetBin=1, the stored word is the sample with bit SAMPLE_W-1 inverted, sign-extended to SINK_W bits. For example, 12'h000 gives 14'h3800, 12'hFFF gives 14'h07FF and 12'h800 gives 14'h0000.
- R6: With cfgOffsetBin=0, the stored word is the sample zero-extended to SINK_W bits.
- R7: outImag is 0 on every output word.
- R8: While outValid=1 and outReady=0, the next cycle still has outValid=1 with outReal, outSop and outEop unchanged.
- R9: Capture continues while a frame is read out. If each readout ends before the next frame is complete, no sample is lost and overflow stays 0.
- R10: If a frame completes while the other memory is still being read out, overflow goes to 1 on that capture edge and stays 1 until reset. Samples arriving before the swap are dropped. Frames already captured are output intact.
- R11: The memories swap on the first cycle in which a complete frame is waiting and the last word of the current readout is loaded. With outReady held high, the waiting frame's first word follows the previous end-of-packet word with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfgOffsetBin | input | 1 | 1: input code is offset binary; 0: plain unsigned |
| sampleValid | input | 1 | Sample strobe, one sample per high cycle |
| sampleData | input | SAMPLE_W | Raw converter code |
| outReady | input | 1 | Transform side accepts the current word |
| outValid | output | 1 | Output word valid |
| outSop | output | 1 | First word of a frame |
| outEop | output | 1 | Last word of a frame |
| outReal | output | SINK_W | Conditioned sample, two's complement |
| outImag | output | SINK_W | Imaginary part, always zero |
| overflow | output | 1 | Sticky: a frame completed before the other memory had drained |

## Verification
The first word of a frame becomes visible two edges after the edge that stores the last sample. The bench drives inputs on the falling edge and checks outValid twice: low one falling edge after the final sample, and high with outSop on the next. Each accepted word is compared on the falling edge where outValid and outReady are both high, because the transfer happens on the rising edge that follows. Stall hold and the back-to-back frame join are checked one falling edge after the cycle that should cause them. Overflow is checked as still 0 on the falling edge where the completing sample is driven, and as 1 on the falling edge after it.

// File: rtl/pp_frame_pkg.sv
package pp_frame_pkg;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic wrEn;     // store conditioned sample
    logic wrBank;   // memory being filled
    logic rdLoad;   // load output register from read memory
    logic rdBank;   // memory being drained
    logic rdFirst;  // word being loaded is frame word 0
    logic rdLast;   // word being loaded is the final frame word
  } fbStrobe_t;

endpackage

// File: rtl/pp_frame_ctrl.sv
module pp_frame_ctrl
  import pp_frame_pkg::*;
#(
  parameter int unsigned FRAME_LEN = 512
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         sampleValid,
  input  logic                         outValid,
  input  logic                         outReady,
  output fbStrobe_t                    stb,
  output logic [$clog2(FRAME_LEN)-1:0] wrAddr,
  output logic [$clog2(FRAME_LEN)-1:0] rdAddr,
  output logic                         overflow
);
  localparam int unsigned AW = $clog2(FRAME_LEN);
  localparam logic [AW-1:0] LAST_IDX = AW'(FRAME_LEN - 1);

  logic          wrBank, rdBank;
  logic [AW-1:0] wrCnt, rdCnt;
  logic          wrDone, rdActive, overflowQ;

  logic wrAccept, wrLast, rdLoad, rdLastLoad, rdFree, frameReady, swapNow;

  always_comb begin
    wrAccept   = sampleValid && !wrDone;
    wrLast     = wrAccept && (wrCnt == LAST_IDX);
    rdLoad     = rdActive && (!outValid || outReady);
    rdLastLoad = rdLoad && (rdCnt == LAST_IDX);
    rdFree     = !rdActive || rdLastLoad;
    frameReady = wrLast || wrDone;
    swapNow    = frameReady && rdFree;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrBank    <= 1'b0;
      rdBank    <= 1'b1;
      wrCnt     <= '0;
      rdCnt     <= '0;
      wrDone    <= 1'b0;
      rdActive  <= 1'b0;
      overflowQ <= 1'b0;
    end else begin
      if (wrAccept) wrCnt <= wrLast ? '0 : wrCnt + 1'b1;
      if (rdLoad) begin
        rdCnt <= rdLastLoad ? '0 : rdCnt + 1'b1;
        if (rdLastLoad) rdActive <= 1'b0;
      end
      if (swapNow) begin
        wrBank   <= ~wrBank;
        rdBank   <= wrBank;
        rdActive <= 1'b1;
        rdCnt    <= '0;
        wrDone   <= 1'b0;
      end else if (wrLast) begin
        // frame complete but the other memory is still draining
        wrDone    <= 1'b1;
        overflowQ <= 1'b1;
      end
    end
  end

  always_comb begin
    stb.wrEn    = wrAccept;
    stb.wrBank  = wrBank;
    stb.rdLoad  = rdLoad;
    stb.rdBank  = rdBank;
    stb.rdFirst = (rdCnt == '0);
    stb.rdLast  = (rdCnt == LAST_IDX);
  end

  assign wrAddr   = wrCnt;
  assign rdAddr   = rdCnt;
  assign overflow = overflowQ;

  // R10
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R10
  bank_separate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdActive |-> (rdBank != wrBank));

  // R10
  drop_while_waiting_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrDone |-> (overflow && !stb.wrEn));

endmodule

// File: rtl/pp_frame_data.sv
module pp_frame_data
  import pp_frame_pkg::*;
#(
  parameter int unsigned SAMPLE_W  = 12,
  parameter int unsigned SINK_W    = 14,
  parameter int unsigned FRAME_LEN = 512
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfgOffsetBin,
  input  logic [SAMPLE_W-1:0]          sampleData,
  input  fbStrobe_t                    stb,
  input  logic [$clog2(FRAME_LEN)-1:0] wrAddr,
  input  logic [$clog2(FRAME_LEN)-1:0] rdAddr,
  input  logic                         outReady,
  output logic                         outValid,
  output logic                         outSop,
  output logic                         outEop,
  output logic [SINK_W-1:0]            outReal,
  output logic [SINK_W-1:0]            outImag
);
  localparam int unsigned EXT_W = SINK_W - SAMPLE_W;
  localparam int unsigned NBANK = 2;

  logic [SAMPLE_W-1:0] fixedCode;
  logic [SINK_W-1:0]   wideWord;
  logic [SINK_W-1:0]   rdWord [NBANK];

  // input conditioning
  always_comb begin
    fixedCode = sampleData;
    if (cfgOffsetBin) fixedCode[SAMPLE_W-1] = ~sampleData[SAMPLE_W-1];
    if (cfgOffsetBin) wideWord = {{EXT_W{fixedCode[SAMPLE_W-1]}}, fixedCode};
    else              wideWord = {{EXT_W{1'b0}}, fixedCode};
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [SINK_W-1:0] frameMem [FRAME_LEN];
    always_ff @(posedge clk) begin
      if (stb.wrEn && (stb.wrBank == 1'(b))) frameMem[wrAddr] <= wideWord;
    end
    assign rdWord[b] = frameMem[rdAddr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      outSop   <= 1'b0;
      outEop   <= 1'b0;
      outReal  <= '0;
    end else if (stb.rdLoad) begin
      outValid <= 1'b1;
      outSop   <= stb.rdFirst;
      outEop   <= stb.rdLast;
      outReal  <= rdWord[stb.rdBank];
    end else if (outReady) begin
      outValid <= 1'b0;
      outSop   <= 1'b0;
      outEop   <= 1'b0;
    end
  end

  assign outImag = '0;

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> (outValid && $stable(outReal) && $stable(outSop) && $stable(outEop)));

  // R4
  marker_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (outSop || outEop) |-> outValid);

  // R4
  marker_distinct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (FRAME_LEN > 1 && outSop) |-> !outEop);

endmodule

// File: rtl/pp_frame_buffer.sv
module pp_frame_buffer
  import pp_frame_pkg::*;
#(
  parameter int unsigned SAMPLE_W  = 12,
  parameter int unsigned SINK_W    = 14,
  parameter int unsigned FRAME_LEN = 512
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfgOffsetBin,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic                outReady,
  output logic                outValid,
  output logic                outSop,
  output logic                outEop,
  output logic [SINK_W-1:0]   outReal,
  output logic [SINK_W-1:0]   outImag,
  output logic                overflow
);
  localparam int unsigned AW = $clog2(FRAME_LEN);

  fbStrobe_t     stb;
  logic [AW-1:0] wrAddr, rdAddr;

  pp_frame_ctrl #(.FRAME_LEN(FRAME_LEN)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sampleValid(sampleValid),
    .outValid   (outValid),
    .outReady   (outReady),
    .stb        (stb),
    .wrAddr     (wrAddr),
    .rdAddr     (rdAddr),
    .overflow   (overflow)
  );

  pp_frame_data #(
    .SAMPLE_W (SAMPLE_W),
    .SINK_W   (SINK_W),
    .FRAME_LEN(FRAME_LEN)
  ) data_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfgOffsetBin(cfgOffsetBin),
    .sampleData  (sampleData),
    .stb         (stb),
    .wrAddr      (wrAddr),
    .rdAddr      (rdAddr),
    .outReady    (outReady),
    .outValid    (outValid),
    .outSop      (outSop),
    .outEop      (outEop),
    .outReal     (outReal),
    .outImag     (outImag)
  );

endmodule

// File: tb/pp_frame_buffer_tb.sv
module pp_frame_buffer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LEN = 16;
  localparam int SW  = 12;
  localparam int KW  = 14;

  logic clk = 1'b0;
  logic rst_n, cfgOffsetBin, sampleValid, outReady;
  logic [SW-1:0] sampleData;
  logic outValid, outSop, outEop, overflow;
  logic [KW-1:0] outReal, outImag;

  pp_frame_buffer #(.SAMPLE_W(SW), .SINK_W(KW), .FRAME_LEN(LEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfgOffsetBin(cfgOffsetBin),
    .sampleValid(sampleValid), .sampleData(sampleData), .outReady(outReady),
    .outValid(outValid), .outSop(outSop), .outEop(outEop),
    .outReal(outReal), .outImag(outImag), .overflow(overflow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [KW-1:0] expQ[$];
  int outIdx = 0;
  int readyMode = 1;   // 0 low, 1 high, 2 random
  bit monOn = 0;
  bit armBack = 0;
  bit expectBack = 0;
  bit stallPrev = 0;
  logic [KW-1:0] stallData;
  logic stallSop, stallEop;
  string dataTag = "R3";

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [KW-1:0] conv(input logic [SW-1:0] s, input logic ofs);
    logic [SW-1:0] f;
    f = s;
    if (ofs) begin
      f[SW-1] = ~s[SW-1];
      return {{(KW-SW){f[SW-1]}}, f};
    end
    return {{(KW-SW){1'b0}}, f};
  endfunction

  // output monitor and ready driver
  always @(negedge clk) begin
    if (monOn) begin
      if (stallPrev)
        chk(outValid && outReal == stallData && outSop == stallSop && outEop == stallEop,
            "R8", "held word", {outValid, outReal}, {1'b1, stallData});
      if (expectBack) begin
        chk(outValid && outSop, "R11", "back-to-back sop", {outValid, outSop}, 2'b11);
        expectBack = 0;
      end
      case (readyMode)
        0: outReady = 1'b0;
        1: outReady = 1'b1;
        default: outReady = (($urandom % 4) != 0);
      endcase
      if (outValid && outReady) begin
        if (expQ.size() == 0) begin
          chk(0, "R3", "unexpected word", outReal, 0);
        end else begin
          logic [KW-1:0] e;
          e = expQ.pop_front();
          chk(outReal == e, dataTag, "data", outReal, e);
          chk(outSop == (outIdx == 0), "R4", "sop", outSop, outIdx == 0);
          chk(outEop == (outIdx == LEN-1), "R4", "eop", outEop, outIdx == LEN-1);
          chk(outImag == '0, "R7", "imag", outImag, 0);
          if (outIdx == LEN-1) begin
            outIdx = 0;
            if (armBack) begin expectBack = 1; armBack = 0; end
          end else outIdx++;
        end
      end
      stallPrev = outValid && !outReady;
      stallData = outReal;
      stallSop  = outSop;
      stallEop  = outEop;
    end
  end

  task automatic drainWait();
    for (int k = 0; k < 2000 && expQ.size() != 0; k++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    total++;
    $display("FAIL watchdog expired act=1 exp=0");
    summary();
  end

  initial begin
    logic [SW-1:0] d;
    void'($urandom(32'd1234));
    rst_n = 1'b0; cfgOffsetBin = 1'b1; sampleValid = 1'b0; sampleData = '0; outReady = 1'b1;
    repeat (3) @(negedge clk);
    chk(!outValid && !outSop && !outEop && !overflow, "R1", "reset outputs",
        {outValid, outSop, outEop, overflow}, 0);
    rst_n = 1'b1;
    monOn = 1;

    // first frame, offset binary, back to back, with corner codes
    dataTag = "R5";
    for (int i = 0; i < LEN; i++) begin
      @(negedge clk);
      chk(!outValid, "R2", "no output while filling", outValid, 0);
      d = (i == 0) ? 12'h000 : (i == 1) ? 12'hFFF : (i == 2) ? 12'h800 : SW'($urandom);
      sampleValid = 1'b1; sampleData = d;
      expQ.push_back(conv(d, 1'b1));
    end
    chk(conv(12'h000, 1'b1) == 14'h3800, "R5", "corner encode", conv(12'h000, 1'b1), 14'h3800);
    @(negedge clk);
    sampleValid = 1'b0;
    chk(!outValid, "R2", "one edge after last sample", outValid, 0);
    @(negedge clk);
    chk(outValid && outSop, "R2", "first word due", {outValid, outSop}, 2'b11);
    drainWait();

    // random data, random ready, sparse input while reading (offset binary)
    dataTag = "R9";
    readyMode = 2;
    for (int i = 0; i < 3*LEN; i++) begin
      @(negedge clk);
      d = SW'($urandom);
      sampleValid = 1'b1; sampleData = d;
      expQ.push_back(conv(d, 1'b1));
      @(negedge clk); sampleValid = 1'b0;
      @(negedge clk);
    end
    readyMode = 1;
    drainWait();
    chk(overflow == 1'b0, "R9", "no overflow with timely reads", overflow, 0);
    chk(outIdx == 0, "R3", "frame boundary after drain", outIdx, 0);

    // unsigned mode
    cfgOffsetBin = 1'b0;
    dataTag = "R6";
    for (int i = 0; i < 2*LEN; i++) begin
      @(negedge clk);
      d = (i == 0) ? 12'h000 : (i == 1) ? 12'hFFF : (i == 2) ? 12'h800 : SW'($urandom);
      sampleValid = 1'b1; sampleData = d;
      expQ.push_back(conv(d, 1'b0));
      @(negedge clk); sampleValid = 1'b0;
    end
    drainWait();
    chk(overflow == 1'b0, "R9", "no overflow in unsigned run", overflow, 0);

    // overflow: stall output, fill two frames, then extra samples dropped
    cfgOffsetBin = 1'b1;
    dataTag = "R10";
    readyMode = 0;
    for (int i = 0; i < 2*LEN; i++) begin
      @(negedge clk);
      if (i == 2*LEN-1) chk(overflow == 1'b0, "R10", "flag before completion", overflow, 0);
      d = SW'($urandom);
      sampleValid = 1'b1; sampleData = d;
      expQ.push_back(conv(d, 1'b1));
    end
    @(negedge clk);
    chk(overflow == 1'b1, "R10", "flag at completion", overflow, 1);
    for (int i = 0; i < 5; i++) begin
      sampleValid = 1'b1; sampleData = SW'($urandom);   // dropped
      @(negedge clk);
    end
    sampleValid = 1'b0;
    repeat (4) @(negedge clk);
    armBack = 1;
    readyMode = 1;
    drainWait();
    chk(overflow == 1'b1, "R10", "flag sticky", overflow, 1);
    for (int i = 0; i < LEN; i++) begin
      @(negedge clk);
      d = SW'($urandom);
      sampleValid = 1'b1; sampleData = d;
      expQ.push_back(conv(d, 1'b1));
    end
    @(negedge clk); sampleValid = 1'b0;
    drainWait();
    chk(expQ.size() == 0, "R3", "all words seen", expQ.size(), 0);

    // reset clears the flag
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(!overflow && !outValid, "R1", "reset clears flag", {overflow, outValid}, 0);
    rst_n = 1'b1;
    summary();
  end

endmodule